// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a single PWM reference into a complementary pair of outputs: a main output that carries the reference and an inverted output that carries its complement. Whenever the reference changes level, both outputs are forced inactive for a programmed dead-time before the newly selected output is switched on. This keeps the high-side and low-side switches of a power stage from conducting together.

The dead-time length comes from an 8-bit code held in an internal register. The code maps to a tick count through four ranges that use different offsets and step sizes, so one byte reaches from 0 up to 1008 ticks. Fine steps are available at short settings and coarse steps at long ones. Ticks are the cycles on which a dead-time clock enable is high. A lock input with a nonzero level freezes the code register against writes.

Top module: `cpwm_deadtime`

## Requirements
- R1: When code bit 7 is 0, the dead-time is the code value in ticks (0 to 127).
- R2: When code bits 7:6 are 2'b10, the dead-time is (64 + code[5:0]) * 2 ticks (128 to 254).
- R3: When code bits 7:5 are 3'b110, the dead-time is (32 + code[4:0]) * 8 ticks (256 to 504).
- R4: When code bits 7:5 are 3'b111, the dead-time is (32 + code[4:0]) * 16 ticks (512 to 1008).
- R5: On a rising reference edge with a nonzero dead-time, the inverted output drops at the clock edge that samples the change. The main output rises at the clock edge carrying the dead-time's last tick. The two outputs are never high together.
- R6: A falling reference edge behaves the same way as a rising edge, with the roles of the main and inverted outputs swapped.
- R7: A reference change during a running dead-time restarts the count with both outputs held low. A pulse shorter than the dead-time never reaches either output.
- R8: With a dead-time of zero, each output follows the reference (main) or its inverse (inverted) at the clock edge that samples the change.
- R9: The dead-time count advances only on clock edges where tick_en is high.
- R10: A write while lock_lvl is nonzero (levels 1, 2 and 3) leaves the code unchanged. A write with lock_lvl equal to 0 takes effect from the next clock edge.
- R11: During reset both outputs are low and the code is 0. From the first clock edge after reset release, the outputs follow the reference level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | PWM reference level |
| tick_en | input | 1 | Dead-time tick enable, one clock wide per tick |
| code_wr | input | 1 | Write strobe for the dead-time code |
| code_wdata | input | 8 | Dead-time code to write |
| lock_lvl | input | 2 | Lock level, where any nonzero value blocks code writes |
| out_main | output | 1 | Main output, active high |
| out_inv | output | 1 | Inverted (complementary) output, active high |

## Verification
Take edge E as the first clock edge that samples a new reference level. The output that turns off changes at E. The output that turns on changes at the edge carrying the dead-time's last tick, which is E plus the dead-time when tick_en stays high, and E itself for a zero code. The bench drives every input on the falling clock edge and samples one time unit after each rising edge. It counts rising edges from E until the newly active output appears, and it counts the tick-enabled edges in the same interval; these two counts are compared with the decoded dead-time. A code write becomes effective one rising edge after its strobe, so each measurement starts only on a later falling edge.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int CODE_W = 8;
    localparam int CNT_W  = 10;
    localparam int LOCK_W = 2;

    typedef logic [CNT_W-1:0] ticks_t;

    typedef struct packed {
        logic   ref_lvl;
        logic   main_on;
        logic   inv_on;
        ticks_t cnt;
    } gate_state_t;

endpackage

// File: rtl/dt_code_reg.sv
module dt_code_reg #(
    parameter int CODE_W = 8,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [LOCK_W-1:0] lock_lvl,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] code_q;
    logic              unlocked;

    assign unlocked = (lock_lvl == '0);

    always_comb begin
        code_d = code_q;
        if (wr && unlocked) begin
            code_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != '0) |=> $stable(code_q)); // R10

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lock_lvl == '0) |=> (code_q == $past(wdata))); // R10

endmodule

// File: rtl/dt_decode.sv
module dt_decode #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks
);

    // Range offsets and step shifts of the four segments
    localparam int OFS_B = 64;
    localparam int OFS_C = 32;
    localparam int SH_B  = 1;
    localparam int SH_C  = 3;
    localparam int SH_D  = 4;
    localparam int MAX_TICKS = (OFS_C + 31) << SH_D;

    logic [CNT_W-1:0] seg_a;
    logic [CNT_W-1:0] seg_b;
    logic [CNT_W-1:0] seg_c;
    logic [CNT_W-1:0] seg_d;

    always_comb begin
        seg_a = CNT_W'(code[CODE_W-2:0]);
        seg_b = (CNT_W'(OFS_B) + CNT_W'(code[CODE_W-3:0])) << SH_B;
        seg_c = (CNT_W'(OFS_C) + CNT_W'(code[CODE_W-4:0])) << SH_C;
        seg_d = (CNT_W'(OFS_C) + CNT_W'(code[CODE_W-4:0])) << SH_D;
    end

    always_comb begin
        if (!code[CODE_W-1]) begin
            ticks = seg_a;
        end else if (!code[CODE_W-2]) begin
            ticks = seg_b;
        end else if (!code[CODE_W-3]) begin
            ticks = seg_c;
        end else begin
            ticks = seg_d;
        end
    end

    always_comb begin
        AST_TICKS_CEIL: assert (int'(ticks) <= MAX_TICKS); // R4
        AST_TOP_RANGE: assert (code[CODE_W-1:CODE_W-3] != 3'b111 || int'(ticks) >= 512); // R4
        AST_MID_RANGE: assert (code[CODE_W-1:CODE_W-3] != 3'b110 || (int'(ticks) >= 256 && int'(ticks) <= 504)); // R3
        AST_LOW_RANGE: assert (code[CODE_W-1:CODE_W-2] != 2'b10 || (int'(ticks) >= 128 && int'(ticks) <= 254)); // R2
    end

endmodule

// File: rtl/dt_gate.sv
module dt_gate
    import dt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ref_in,
    input  logic   tick_en,
    input  ticks_t dt_ticks,
    output logic   out_main,
    output logic   out_inv
);

    gate_state_t s_d;
    gate_state_t s_q;
    logic        level_change;
    logic        counting;
    logic        last_tick;

    assign level_change = (ref_in != s_q.ref_lvl);
    assign counting     = (s_q.cnt != '0);
    assign last_tick    = tick_en && (s_q.cnt == ticks_t'(1));

    always_comb begin
        s_d = s_q;
        if (level_change) begin
            s_d.ref_lvl = ref_in;
            if (dt_ticks == '0) begin
                s_d.main_on = ref_in;
                s_d.inv_on  = !ref_in;
                s_d.cnt     = '0;
            end else begin
                s_d.main_on = 1'b0;
                s_d.inv_on  = 1'b0;
                s_d.cnt     = dt_ticks;
            end
        end else if (counting) begin
            if (tick_en) begin
                s_d.cnt = s_q.cnt - ticks_t'(1);
            end
            if (last_tick) begin
                s_d.main_on = s_q.ref_lvl;
                s_d.inv_on  = !s_q.ref_lvl;
            end
        end else begin
            s_d.main_on = s_q.ref_lvl;
            s_d.inv_on  = !s_q.ref_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_main = s_q.main_on;
    assign out_inv  = s_q.inv_on;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_main && out_inv)); // R5

    AST_EDGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_in != s_q.ref_lvl && dt_ticks != '0) |=> (!out_main && !out_inv)); // R7

    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_in != s_q.ref_lvl && dt_ticks == '0) |=> (out_main == $past(ref_in) && out_inv == !$past(ref_in))); // R8

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && s_q.cnt != '0 && ref_in == s_q.ref_lvl) |=> (s_q.cnt == $past(s_q.cnt))); // R9

    AST_HELD_DURING_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt > ticks_t'(1) && ref_in == s_q.ref_lvl) |=> (!out_main && !out_inv)); // R5

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import dt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              tick_en,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic [LOCK_W-1:0] lock_lvl,
    output logic              out_main,
    output logic              out_inv
);

    logic [CODE_W-1:0] code_q;
    ticks_t            dt_ticks;

    dt_code_reg #(
        .CODE_W (CODE_W),
        .LOCK_W (LOCK_W)
    ) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (code_wr),
        .wdata    (code_wdata),
        .lock_lvl (lock_lvl),
        .code     (code_q)
    );

    dt_decode #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .code  (code_q),
        .ticks (dt_ticks)
    );

    dt_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .tick_en  (tick_en),
        .dt_ticks (dt_ticks),
        .out_main (out_main),
        .out_inv  (out_inv)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_main && !out_inv)); // R11

endmodule

// File: tb/tb_cpwm_deadtime.sv
module tb_cpwm_deadtime;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       tick_en = 1'b1;
    logic       code_wr = 1'b0;
    logic [7:0] code_wdata = '0;
    logic [1:0] lock_lvl = '0;
    logic       out_main;
    logic       out_inv;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  sparse_ticks = 1'b0;
    int  div_cnt = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cpwm_deadtime dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .tick_en    (tick_en),
        .code_wr    (code_wr),
        .code_wdata (code_wdata),
        .lock_lvl   (lock_lvl),
        .out_main   (out_main),
        .out_inv    (out_inv)
    );

    always @(negedge clk) begin
        if (sparse_ticks) begin
            div_cnt <= (div_cnt == 2) ? 0 : div_cnt + 1;
            tick_en <= (div_cnt == 2);
        end else begin
            div_cnt <= 0;
            tick_en <= 1'b1;
        end
    end

    function automatic int exp_dt(input int c);
        if (c < 128) return c;
        else if (c < 192) return (64 + (c % 64)) * 2;
        else if (c < 224) return (32 + (c % 32)) * 8;
        else return (32 + (c % 32)) * 16;
    endfunction

    function automatic string range_tag(input int c);
        if (c < 128) return "R1";
        else if (c < 192) return "R2";
        else if (c < 224) return "R3";
        else return "R4";
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_code(input int v);
        @(negedge clk);
        code_wr = 1'b1;
        code_wdata = 8'(v);
        @(negedge clk);
        code_wr = 1'b0;
    endtask

    // Drives a new reference level, then counts rising edges (and ticks) from
    // the sampling edge until the newly selected output turns on.
    task automatic measure(input bit lvl, output int cycles, output int ticks, output int overlap);
        bit tk;
        @(negedge clk);
        ref_in = lvl;
        @(posedge clk);
        #1;
        cycles = 0;
        ticks = 0;
        overlap = 0;
        while (((lvl ? out_main : out_inv) == 1'b0) && cycles < 2500) begin
            if (out_main || out_inv) overlap++;
            @(negedge clk);
            #1;
            tk = tick_en;
            @(posedge clk);
            #1;
            cycles++;
            if (tk) ticks++;
        end
        if (lvl ? out_inv : out_main) overlap++;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int cyc, tks, ovl, mains;
        repeat (3) @(posedge clk);
        #1;
        check("R11", {30'd0, out_main, out_inv}, 0, "outputs in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11", {30'd0, out_main, out_inv}, 1, "outputs after release, ref low");

        // Exhaustive sweep of every code, rising and falling edge
        for (int c = 0; c < 256; c++) begin
            write_code(c);
            measure(1'b1, cyc, tks, ovl);
            check(range_tag(c), cyc, exp_dt(c), $sformatf("rise delay code %0d", c));
            check("R5", ovl, 0, $sformatf("overlap on rise code %0d", c));
            measure(1'b0, cyc, tks, ovl);
            check("R6", cyc, exp_dt(c), $sformatf("fall delay code %0d", c));
            check("R6", ovl, 0, $sformatf("overlap on fall code %0d", c));
        end

        // Zero dead-time: follow at the sampling edge
        write_code(0);
        measure(1'b1, cyc, tks, ovl);
        check("R8", cyc, 0, "zero code rise delay");
        check("R8", {31'd0, out_inv}, 0, "zero code inverted off");

        // Sparse ticks: delay counted in ticks, not cycles
        write_code(6);
        measure(1'b0, cyc, tks, ovl);
        sparse_ticks = 1'b1;
        measure(1'b1, cyc, tks, ovl);
        check("R9", tks, 6, "ticks until main on");
        check("R9", int'(cyc >= 16), 1, "cycles stretched by sparse ticks");
        sparse_ticks = 1'b0;

        // Short pulse suppressed, count restarts on fall
        write_code(10);
        measure(1'b0, cyc, tks, ovl);
        mains = 0;
        @(negedge clk);
        ref_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            if (out_main) mains++;
        end
        measure(1'b0, cyc, tks, ovl);
        check("R7", mains, 0, "main during short pulse");
        check("R7", cyc, 10, "fall delay after restart");
        check("R7", ovl, 0, "main after short pulse");

        // Lock levels block writes
        write_code(20);
        for (int l = 1; l < 4; l++) begin
            @(negedge clk);
            lock_lvl = 2'(l);
            write_code(100 + l);
            measure(1'b1, cyc, tks, ovl);
            check("R10", cyc, 20, $sformatf("rise delay under lock %0d", l));
            measure(1'b0, cyc, tks, ovl);
        end
        @(negedge clk);
        lock_lvl = 2'd0;
        write_code(3);
        measure(1'b1, cyc, tks, ovl);
        check("R10", cyc, 3, "rise delay after unlock write");

        done = 1'b1;
        finish_run();
    end

endmodule